// File: doc/BRIEF.md
# Prescaled Modulus Down-Counter Timer

This block is a 16-bit timer that counts down from a programmable start value, one step per prescaled tick. When it arrives at zero it raises an underflow flag. On the next tick it copies the start value back in and keeps going, so it produces a periodic event. Software controls it through four word registers on a single-cycle strobe bus:

- a control word with run enable, rate select, clear mode and interrupt enable;
- a start (load) value;
- the live count, which can be read, and which forces a reload when written;
- a status word that holds the underflow flag.

The interrupt line is the flag gated by the interrupt enable.

The counter is run by a three-state machine:

- **Off**: the count is parked at all ones.
- **Run**: counting down.
- **Zero**: the count is at zero and waits for the tick that reloads it.

The transitions are:

- Off→Run when the run enable is set.
- Run→Zero when a tick takes the count from 1 to 0.
- Zero→Run on the next tick, which reloads a non-zero start value.
- Zero→Zero when a zero start value is reloaded.
- Run→Run or Zero when software writes the count register, which forces a reload.
- Run→Off or Zero→Off when the run enable is cleared.

The prescaler is a 4-bit free-running divider. It is cleared on every reload, and every reload also copies the pending rate code into the active one.

Register map, by `bus_addr`:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bit0 run enable, bits[2:1] rate code, bit3 access-clear mode, bit4 interrupt enable |
| 1 | Start value | 16-bit reload value |
| 2 | Count | live count on read; a write forces a reload |
| 3 | Status | bit0 underflow flag |

Top module: `moddown_timer`

## Requirements
- R1: After reset the control word reads 0, the start value reads 0, the count reads 0xFFFF and the status word and `irq` are 0.
- R2: While the run enable (control bit0) is 0 the count reads 0xFFFF. After enabling, counting starts from 0xFFFF and no underflow flag appears.
- R3: Rate code (control bits[2:1]) 00, 01, 10 and 11 give one decrement every 1, 4, 8 and 16 clocks. After a reload the first decrement comes that many clocks later.
- R4: A newly written rate code does not change the active rate until the next reload.
- R5: The flag (status bit0) is set in the cycle the count becomes 0x0000. The following tick reloads the count from the start value.
- R6: A write to the count register while running reloads the count from the start value at that clock edge, whatever data is written.
- R7: With the access-clear mode (control bit3) at 0:
  - writing status with bit0=1 clears the flag;
  - writing status with bit0=0 has no effect;
  - accessing the count register has no effect on the flag.
- R8: With the access-clear mode at 1, any read or write of the count register clears the flag. Writing 1 to status bit0 does not clear it.
- R9: `irq` is 1 exactly when the flag is 1 and the interrupt enable (control bit4) is 1.
- R10: The control word (bits[4:0], upper bits read 0) and the start value read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select (0 control, 1 start, 2 count, 3 status) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid combinationally in the access cycle |
| irq | output | 1 | Underflow interrupt request |

## Verification
The assertions assume that each bus access lasts exactly one strobed cycle and that the address is stable while `bus_sel` is high. They also assume that software sets a non-zero start value before it forces a reload, so a flag rise always coincides with a count of zero. The stimulus drives every access for one clock right after a rising edge and drops the strobe after the next edge. Flag-clear tests are run with the counter disabled, so that a new underflow cannot race with the clear being checked.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_ZERO = 2'd2
    } cnt_state_e;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_START = 2'd1;
    localparam logic [1:0] A_COUNT = 2'd2;
    localparam logic [1:0] A_STAT  = 2'd3;

    // bit4 irq_en, bit3 fast_clr, bits2:1 rate, bit0 run_en
    typedef struct packed {
        logic       irq_en;
        logic       fast_clr;
        logic [1:0] rate;
        logic       run_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // log2 of the division rate for each rate code
    function automatic int unsigned rate_shift(input logic [1:0] code);
        unique case (code)
            2'd0:    return 0;
            2'd1:    return 2;
            2'd2:    return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/mdt_regs.sv
module mdt_regs
    import mdt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              flag,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] start_val,
    output logic              cnt_wr,
    output logic              cnt_access,
    output logic              stat_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    logic wr_ctrl, wr_start;

    assign wr_ctrl    = bus_sel && bus_wr && (bus_addr == A_CTRL);
    assign wr_start   = bus_sel && bus_wr && (bus_addr == A_START);
    assign cnt_wr     = bus_sel && bus_wr && (bus_addr == A_COUNT);
    assign cnt_access = bus_sel && (bus_addr == A_COUNT);
    assign stat_wr    = bus_sel && bus_wr && (bus_addr == A_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            start_val <= '0;
        end else begin
            if (wr_ctrl)  ctrl      <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_start) start_val <= bus_wdata;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'(ctrl);
            A_START: bus_rdata = start_val;
            A_COUNT: bus_rdata = cnt_val;
            default: bus_rdata = DATA_W'(flag);
        endcase
    end

    a_r10_ctrl_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl == ctrl_t'($past(bus_wdata[CTRL_W-1:0]))));

endmodule

// File: rtl/mdt_prescaler.sv
module mdt_prescaler
    import mdt_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       reload,
    input  logic [1:0] pend_rate,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic [1:0]       act_q;

    assign mask = PRE_W'((1 << rate_shift(act_q)) - 1);
    assign tick = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            act_q <= '0;
        end else begin
            if (reload) act_q <= pend_rate;
            if (!run || reload) pre_q <= '0;
            else                pre_q <= pre_q + PRE_W'(1);
        end
    end

    a_r4_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(act_q));

    a_r3_fresh_after_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && run) |=> (pre_q == '0));

endmodule

// File: rtl/mdt_counter.sv
module mdt_counter
    import mdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             reload,
    output logic             zero_hit
);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        reload   = 1'b0;
        zero_hit = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = '1;
                if (en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_OFF;
                    cnt_d   = '1;
                end else if (cnt_wr) begin
                    reload = 1'b1;
                end else if (tick) begin
                    cnt_d = cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) begin
                        state_d  = ST_ZERO;
                        zero_hit = 1'b1;
                    end
                end
            end
            ST_ZERO: begin
                if (!en) begin
                    state_d = ST_OFF;
                    cnt_d   = '1;
                end else if (cnt_wr || tick) begin
                    reload = 1'b1;
                end
            end
            default: begin
                state_d = ST_OFF;
                cnt_d   = '1;
            end
        endcase
        if (reload) begin
            cnt_d = start_val;
            if (start_val == '0) begin
                state_d  = ST_ZERO;
                zero_hit = 1'b1;
            end else begin
                state_d  = ST_RUN;
            end
        end
    end

    assign cnt     = cnt_q;
    assign running = (state_q != ST_OFF);

    a_r2_off_parks: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '1));

    a_r5_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ZERO && en && tick) |=> (cnt_q == $past(start_val)));

    a_r6_write_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && cnt_wr) |=> (cnt_q == $past(start_val)));

endmodule

// File: rtl/mdt_flag.sv
module mdt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic fast_clr,
    input  logic cnt_access,
    input  logic stat_wr,
    input  logic clr_bit,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    logic clr_evt;

    assign clr_evt = fast_clr ? cnt_access : (stat_wr && clr_bit);

    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_evt) flag <= 1'b0;
    end

    assign irq = flag && irq_en;

    a_r8_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_clr && cnt_access && !set_evt) |=> !flag);

    a_r7_write_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_clr && stat_wr && !clr_bit && flag) |=> flag);

endmodule

// File: rtl/moddown_timer.sv
module moddown_timer
    import mdt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] start_val, cnt_val;
    logic             cnt_wr, cnt_access, stat_wr;
    logic             flag, tick, running, reload, zero_hit;

    mdt_regs #(.DATA_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_val    (cnt_val),
        .flag       (flag),
        .ctrl       (ctrl),
        .start_val  (start_val),
        .cnt_wr     (cnt_wr),
        .cnt_access (cnt_access),
        .stat_wr    (stat_wr),
        .bus_rdata  (bus_rdata)
    );

    mdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .reload    (reload),
        .pend_rate (ctrl.rate),
        .tick      (tick)
    );

    mdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl.run_en),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .start_val (start_val),
        .cnt       (cnt_val),
        .running   (running),
        .reload    (reload),
        .zero_hit  (zero_hit)
    );

    mdt_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_evt    (zero_hit),
        .fast_clr   (ctrl.fast_clr),
        .cnt_access (cnt_access),
        .stat_wr    (stat_wr),
        .clr_bit    (bus_wdata[0]),
        .irq_en     (ctrl.irq_en),
        .flag       (flag),
        .irq        (irq)
    );

    a_r5_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt_val == '0));

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ctrl.irq_en));

endmodule

// File: tb/moddown_timer_tb.sv
`timescale 1ns/1ps
module moddown_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    localparam logic [1:0] CTRL = 2'd0, START = 2'd1, COUNT = 2'd2, STAT = 2'd3;

    always #2.5 clk = ~clk;

    moddown_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: compares read data with the expected item queue
    always @(negedge clk) begin
        if (bus_sel && !bus_wr) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard: read with no expected item, actual=%h expected=none", bus_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    failures++;
                    $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(CTRL, 16'h0000, "R1 ctrl");
        rd(START, 16'h0000, "R1 start");
        rd(COUNT, 16'hFFFF, "R1 count");
        rd(STAT, 16'h0000, "R1 status");
        chk_irq(1'b0, "R1 irq");

        // R10 readback, R2 start from all ones
        wr(START, 16'd5);
        rd(START, 16'd5, "R10 start");
        wr(CTRL, 16'h0011);
        rd(CTRL, 16'h0011, "R10 ctrl");
        rd(COUNT, 16'hFFFF, "R2 first count");
        rd(COUNT, 16'hFFFE, "R2 counting");
        rd(STAT, 16'h0000, "R2 no early flag");

        // R6 forced reload, R5 underflow and reload, rate 1
        wr(COUNT, 16'h1234);
        rd(COUNT, 16'd5, "R6 reload");
        rd(COUNT, 16'd4, "R3 rate1");
        idle(2);
        rd(COUNT, 16'd1, "R3 rate1 steady");
        rd(STAT, 16'h0001, "R5 flag set");
        rd(COUNT, 16'd5, "R5 reload after zero");
        chk_irq(1'b1, "R9 irq on");

        // R4 pending rate not active before reload
        wr(CTRL, 16'h0013);
        rd(COUNT, 16'd3, "R4 old rate");
        rd(COUNT, 16'd2, "R4 old rate");

        // R3 rate 4
        wr(COUNT, 16'h0000);
        rd(COUNT, 16'd5, "R3 rate4 start");
        idle(2);
        rd(COUNT, 16'd5, "R3 rate4 hold");
        rd(COUNT, 16'd4, "R3 rate4 step");

        // R3 rate 8
        wr(CTRL, 16'h0015);
        wr(COUNT, 16'h0000);
        rd(COUNT, 16'd5, "R3 rate8 start");
        idle(6);
        rd(COUNT, 16'd5, "R3 rate8 hold");
        rd(COUNT, 16'd4, "R3 rate8 step");

        // R3 rate 16
        wr(CTRL, 16'h0017);
        wr(COUNT, 16'h0000);
        rd(COUNT, 16'd5, "R3 rate16 start");
        idle(14);
        rd(COUNT, 16'd5, "R3 rate16 hold");
        rd(COUNT, 16'd4, "R3 rate16 step");

        // R2 disable parks at all ones
        wr(CTRL, 16'h0011);
        wr(COUNT, 16'h0000);
        wr(CTRL, 16'h0010);
        idle(1);
        rd(COUNT, 16'hFFFF, "R2 parked");
        idle(3);
        rd(COUNT, 16'hFFFF, "R2 still parked");

        // R7 write-one clear mode
        rd(STAT, 16'h0001, "R7 flag held");
        wr(STAT, 16'hFFFE);
        rd(STAT, 16'h0001, "R7 write zero ignored");
        rd(COUNT, 16'hFFFF, "R7 count read");
        rd(STAT, 16'h0001, "R7 count access ignored");
        wr(STAT, 16'h0001);
        rd(STAT, 16'h0000, "R7 write one clears");
        chk_irq(1'b0, "R9 irq off");

        // R8 access clear mode
        wr(CTRL, 16'h0019);
        idle(1);
        wr(START, 16'd2);
        wr(COUNT, 16'h0000);
        idle(2);
        wr(CTRL, 16'h0018);
        rd(STAT, 16'h0001, "R8 flag set");
        chk_irq(1'b1, "R9 irq on again");
        wr(STAT, 16'h0001);
        rd(STAT, 16'h0001, "R8 write one ignored");
        wr(CTRL, 16'h0008);
        chk_irq(1'b0, "R9 irq masked");
        rd(COUNT, 16'hFFFF, "R8 count read");
        rd(STAT, 16'h0000, "R8 access cleared");

        idle(2);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: pending actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule